// File: doc/BRIEF.md
# Sparse Operand Match Unit

This block pairs operands for sparse row-by-row matrix multiplication. A bundle of nonzeros from one row of the left matrix is first written into a small content-addressable store. Each entry is keyed by the element's column index and holds the slot address where that element's value sits in a side value store. After the bundle is loaded, the block takes in a stream of right-matrix nonzeros. Each one is tagged with its row index, its column index and its value.

When a right element's row index equals a stored key, the block forms a work item and puts it in a small synchronous queue. The item carries the matching left value, the right value and the right element's column index, which becomes the column of the resulting partial product. A downstream multiplier drains the queue with valid/ready. Values are treated as opaque words.

A long row may arrive as several bundles in a row. Each bundle states its element count and whether it closes the row, and the end-of-row flag stays visible on an output until the next bundle starts.

Top module: `cam_index_match`

## Requirements
- R1: After reset, no entry is valid, `outValid` is 0, `rowEnd` is 0, and both `loadReady` and `probeReady` are 1, so any probe misses.
- R2: A load is accepted while `loadReady` is 1. In the cycle it is accepted (`loadStart` high), every valid bit is cleared, so keys from an earlier bundle no longer hit.
- R3: From the accepted `loadStart` until the last of `loadCount` elements has been written, `loadReady` and `probeReady` are 0. Both return to 1 in the cycle after the last element is written.
- R4: Suppose an accepted probe's row index equals a valid key. Then exactly one item is queued and appears at the queue head no earlier than the following cycle. The item is `outLeft` = the value loaded with that key, `outRight` = `probeData` and `outCol` = `probeCol`. Items leave in acceptance order.
- R5: A probe that matches no valid key is consumed in the cycle it is accepted and queues nothing.
- R6: When the same key was loaded more than once, a hit reports the entry loaded earliest in the bundle, that is, the lowest position.
- R7: `probeReady` is 0 whenever the queue holds `Q_DEPTH` items, so no hit is ever dropped. The queue accepts exactly `Q_DEPTH` items before it blocks.
- R8: Only the first `loadCount` elements of a bundle are stored. Element beats arriving after that are ignored. A count of 0 leaves the unit empty and ready in the next cycle. `rowEnd` shows the `loadEndRow` value of the most recently accepted bundle.
- R9: A bundle of exactly `CAM_DEPTH` elements fills every entry, and every one of them, including the last, can hit.
- R10: While `outValid` is 1 and `outReady` is 0, the head item stays unchanged and `outValid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStart | input | 1 | Begins a new bundle (taken when loadReady is 1) |
| loadCount | input | $clog2(CAM_DEPTH+1) | Elements in the bundle; values above CAM_DEPTH are clamped |
| loadEndRow | input | 1 | Bundle closes the current left row |
| loadReady | output | 1 | Unit can accept loadStart |
| loadValid | input | 1 | One bundle element on loadKey/loadData |
| loadKey | input | KEY_W | Column index of the left element |
| loadData | input | DATA_W | Value of the left element |
| rowEnd | output | 1 | End-of-row flag of the current bundle |
| probeValid | input | 1 | Right element offered |
| probeReady | output | 1 | Right element accepted this cycle if valid |
| probeRow | input | KEY_W | Row index of the right element (search key) |
| probeCol | input | KEY_W | Column index of the right element |
| probeData | input | DATA_W | Value of the right element |
| outValid | output | 1 | Work item at queue head |
| outReady | input | 1 | Downstream takes the head item |
| outLeft | output | DATA_W | Left operand value |
| outRight | output | DATA_W | Right operand value |
| outCol | output | KEY_W | Column of the partial product |

## Verification
The bench builds the unit with CAM_DEPTH 8, KEY_W 8, DATA_W 16 and Q_DEPTH 4. The small store can be filled to its last entry with a handful of load beats, so the full-capacity hit is checked directly. The four-deep queue reaches its full condition after four stalled hits, which exercises the blocking of probes and the holding of the head item within a few cycles. Duplicate keys, misses, zero-length bundles, surplus load beats and a second bundle that must hide the first are all covered at these sizes.

// File: rtl/camMatchPkg.sv
package camMatchPkg;

  // Strobes from the sequencing control to the storage datapath
  typedef struct packed {
    logic clearAll;   // drop every valid bit (new bundle accepted)
    logic writeEn;    // store one bundle element at writeIdx
    logic probeFire;  // a right element is accepted this cycle
  } ctrlStrobeT;

endpackage

// File: rtl/cam_match_ctrl.sv
module cam_match_ctrl
  import camMatchPkg::*;
#(
  parameter int CAM_DEPTH = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               loadStart,
  input  logic [$clog2(CAM_DEPTH+1)-1:0]     loadCount,
  input  logic                               loadEndRow,
  input  logic                               loadValid,
  input  logic                               probeValid,
  input  logic                               queueFull,
  output ctrlStrobeT                         strobes,
  output logic [$clog2(CAM_DEPTH)-1:0]       writeIdx,
  output logic                               loadReady,
  output logic                               probeReady,
  output logic                               rowEnd
);

  localparam int CNT_W = $clog2(CAM_DEPTH + 1);
  localparam int IDX_W = $clog2(CAM_DEPTH);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(CAM_DEPTH);

  typedef enum logic {ST_READY, ST_LOAD} stateT;

  stateT            state;
  logic [CNT_W-1:0] wrCnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] clamped;
  logic [CNT_W-1:0] wrNext;

  always_comb begin
    clamped = (loadCount > CAP) ? CAP : loadCount;
    wrNext  = wrCnt + CNT_W'(1);
  end

  always_comb begin
    loadReady          = (state == ST_READY);
    probeReady         = (state == ST_READY) && !queueFull;
    strobes.clearAll   = loadStart && loadReady;
    strobes.writeEn    = (state == ST_LOAD) && loadValid;
    strobes.probeFire  = probeValid && probeReady;
    writeIdx           = wrCnt[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_READY;
      wrCnt  <= '0;
      target <= '0;
      rowEnd <= 1'b0;
    end else if (strobes.clearAll) begin
      target <= clamped;
      wrCnt  <= '0;
      rowEnd <= loadEndRow;
      state  <= (clamped == '0) ? ST_READY : ST_LOAD;
    end else if (strobes.writeEn) begin
      wrCnt <= wrNext;
      if (wrNext == target) begin
        state <= ST_READY;
      end
    end
  end

endmodule

// File: rtl/cam_match_dp.sv
module cam_match_dp
  import camMatchPkg::*;
#(
  parameter int CAM_DEPTH = 32,
  parameter int KEY_W     = 16,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobeT                   strobes,
  input  logic [$clog2(CAM_DEPTH)-1:0] writeIdx,
  input  logic [KEY_W-1:0]             loadKey,
  input  logic [DATA_W-1:0]            loadData,
  input  logic [KEY_W-1:0]             probeRow,
  output logic                         hit,
  output logic [DATA_W-1:0]            leftVal,
  output logic [CAM_DEPTH-1:0]         validBits
);

  localparam int IDX_W = $clog2(CAM_DEPTH);

  logic [KEY_W-1:0]  keyMem  [CAM_DEPTH];
  logic [IDX_W-1:0]  addrMem [CAM_DEPTH];
  logic [DATA_W-1:0] valMem  [CAM_DEPTH];
  logic [CAM_DEPTH-1:0] matchVec;
  logic [IDX_W-1:0]  hitIdx;
  logic [IDX_W-1:0]  slotAddr;

  // One key/payload entry per position, each with its own comparator
  for (genvar i = 0; i < CAM_DEPTH; i++) begin : g_entry
    logic selThis;
    assign selThis = strobes.writeEn && (writeIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validBits[i] <= 1'b0;
      end else if (strobes.clearAll) begin
        validBits[i] <= 1'b0;
      end else if (selThis) begin
        validBits[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (selThis) begin
        keyMem[i]  <= loadKey;
        addrMem[i] <= writeIdx;
      end
    end

    assign matchVec[i] = validBits[i] && (keyMem[i] == probeRow);
  end

  // Side value store, addressed by the slot the entry payload names
  always_ff @(posedge clk) begin
    if (strobes.writeEn) begin
      valMem[writeIdx] <= loadData;
    end
  end

  // Lowest-numbered matching entry wins
  always_comb begin
    hitIdx = '0;
    for (int i = CAM_DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitIdx = IDX_W'(i);
      end
    end
    hit      = |matchVec;
    slotAddr = addrMem[hitIdx];
    leftVal  = valMem[slotAddr];
  end

endmodule

// File: rtl/cam_match_fifo.sv
module cam_match_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [CW-1:0]    fill;
  logic             doPush;
  logic             doPop;

  always_comb begin
    full    = (fill == CW'(DEPTH));
    empty   = (fill == '0);
    doPush  = push && !full;
    doPop   = pop && !empty;
    popData = mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (doPush) begin
      mem[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/cam_index_match.sv
module cam_index_match
  import camMatchPkg::*;
#(
  parameter int CAM_DEPTH = 32,
  parameter int KEY_W     = 16,
  parameter int DATA_W    = 32,
  parameter int Q_DEPTH   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           loadStart,
  input  logic [$clog2(CAM_DEPTH+1)-1:0] loadCount,
  input  logic                           loadEndRow,
  output logic                           loadReady,
  input  logic                           loadValid,
  input  logic [KEY_W-1:0]               loadKey,
  input  logic [DATA_W-1:0]              loadData,
  output logic                           rowEnd,
  input  logic                           probeValid,
  output logic                           probeReady,
  input  logic [KEY_W-1:0]               probeRow,
  input  logic [KEY_W-1:0]               probeCol,
  input  logic [DATA_W-1:0]              probeData,
  output logic                           outValid,
  input  logic                           outReady,
  output logic [DATA_W-1:0]              outLeft,
  output logic [DATA_W-1:0]              outRight,
  output logic [KEY_W-1:0]               outCol
);

  localparam int IDX_W  = $clog2(CAM_DEPTH);
  localparam int ITEM_W = 2 * DATA_W + KEY_W;

  ctrlStrobeT           strobes;
  logic [IDX_W-1:0]     writeIdx;
  logic                 qFull;
  logic                 qEmpty;
  logic                 dpHit;
  logic [DATA_W-1:0]    leftVal;
  logic [CAM_DEPTH-1:0] validBits;
  logic [ITEM_W-1:0]    headItem;

  cam_match_ctrl #(.CAM_DEPTH(CAM_DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .loadStart  (loadStart),
    .loadCount  (loadCount),
    .loadEndRow (loadEndRow),
    .loadValid  (loadValid),
    .probeValid (probeValid),
    .queueFull  (qFull),
    .strobes    (strobes),
    .writeIdx   (writeIdx),
    .loadReady  (loadReady),
    .probeReady (probeReady),
    .rowEnd     (rowEnd)
  );

  cam_match_dp #(
    .CAM_DEPTH (CAM_DEPTH),
    .KEY_W     (KEY_W),
    .DATA_W    (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .writeIdx  (writeIdx),
    .loadKey   (loadKey),
    .loadData  (loadData),
    .probeRow  (probeRow),
    .hit       (dpHit),
    .leftVal   (leftVal),
    .validBits (validBits)
  );

  cam_match_fifo #(.WIDTH(ITEM_W), .DEPTH(Q_DEPTH)) queue_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobes.probeFire && dpHit),
    .pushData ({leftVal, probeData, probeCol}),
    .pop      (outReady),
    .popData  (headItem),
    .full     (qFull),
    .empty    (qEmpty)
  );

  always_comb begin
    outValid = !qEmpty;
    {outLeft, outRight, outCol} = headItem;
  end

endmodule

// File: rtl/cam_index_match_chk.sv
module cam_index_match_chk #(
  parameter int CAM_DEPTH = 32,
  parameter int KEY_W     = 16,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 loadStart,
  input logic                 loadReady,
  input logic                 probeValid,
  input logic                 probeReady,
  input logic                 outValid,
  input logic                 outReady,
  input logic [DATA_W-1:0]    outLeft,
  input logic [DATA_W-1:0]    outRight,
  input logic [KEY_W-1:0]     outCol,
  input logic                 qFull,
  input logic                 dpHit,
  input logic [CAM_DEPTH-1:0] validBits
);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loadStart && loadReady) |=> (validBits == '0));

  assert_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    !loadReady |-> !probeReady);

  assert_hit_queued_R4: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && probeReady && dpHit) |=> outValid);

  assert_miss_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && probeReady && !dpHit && !(outValid && outReady))
      |=> (outValid == $past(outValid)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> !probeReady);

  assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady)
      |=> (outValid && $stable(outLeft) && $stable(outRight) && $stable(outCol)));

endmodule

bind cam_index_match cam_index_match_chk #(
  .CAM_DEPTH (CAM_DEPTH),
  .KEY_W     (KEY_W),
  .DATA_W    (DATA_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .loadStart  (loadStart),
  .loadReady  (loadReady),
  .probeValid (probeValid),
  .probeReady (probeReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outLeft    (outLeft),
  .outRight   (outRight),
  .outCol     (outCol),
  .qFull      (qFull),
  .dpHit      (dpHit),
  .validBits  (validBits)
);

// File: tb/cam_index_match_tb.sv
module cam_index_match_tb_top;

  localparam int CAM_DEPTH = 8;
  localparam int KEY_W     = 8;
  localparam int DATA_W    = 16;
  localparam int Q_DEPTH   = 4;
  localparam int CNT_W     = $clog2(CAM_DEPTH + 1);

  // Probe vectors: {row, col, data, expectHit, expectLeft}
  localparam int VW = 2 * KEY_W + 2 * DATA_W + 1;
  localparam logic [VW-1:0] VEC [0:6] = '{
    {8'd3,  8'd1, 16'hA001, 1'b1, 16'h0100},
    {8'd7,  8'd2, 16'hA002, 1'b1, 16'h0101},
    {8'd5,  8'd3, 16'hA003, 1'b0, 16'h0000},
    {8'd12, 8'd4, 16'hA004, 1'b1, 16'h0104},
    {8'd9,  8'd5, 16'hA005, 1'b1, 16'h0102},
    {8'd0,  8'd6, 16'hA006, 1'b0, 16'h0000},
    {8'd13, 8'd7, 16'hA007, 1'b0, 16'h0000}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadStart = 1'b0;
  logic [CNT_W-1:0]  loadCount = '0;
  logic              loadEndRow = 1'b0;
  logic              loadReady;
  logic              loadValid = 1'b0;
  logic [KEY_W-1:0]  loadKey = '0;
  logic [DATA_W-1:0] loadData = '0;
  logic              rowEnd;
  logic              probeValid = 1'b0;
  logic              probeReady;
  logic [KEY_W-1:0]  probeRow = '0;
  logic [KEY_W-1:0]  probeCol = '0;
  logic [DATA_W-1:0] probeData = '0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [DATA_W-1:0] outLeft;
  logic [DATA_W-1:0] outRight;
  logic [KEY_W-1:0]  outCol;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cam_index_match #(
    .CAM_DEPTH (CAM_DEPTH),
    .KEY_W     (KEY_W),
    .DATA_W    (DATA_W),
    .Q_DEPTH   (Q_DEPTH)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .loadStart  (loadStart),
    .loadCount  (loadCount),
    .loadEndRow (loadEndRow),
    .loadReady  (loadReady),
    .loadValid  (loadValid),
    .loadKey    (loadKey),
    .loadData   (loadData),
    .rowEnd     (rowEnd),
    .probeValid (probeValid),
    .probeReady (probeReady),
    .probeRow   (probeRow),
    .probeCol   (probeCol),
    .probeData  (probeData),
    .outValid   (outValid),
    .outReady   (outReady),
    .outLeft    (outLeft),
    .outRight   (outRight),
    .outCol     (outCol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic startBundle(input int cnt, input logic endRow);
    loadStart  = 1'b1;
    loadCount  = CNT_W'(cnt);
    loadEndRow = endRow;
    @(negedge clk);
    loadStart  = 1'b0;
  endtask

  task automatic loadElem(input int key, input int data);
    loadValid = 1'b1;
    loadKey   = KEY_W'(key);
    loadData  = DATA_W'(data);
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic probe(input int row, input int col, input int data);
    probeValid = 1'b1;
    probeRow   = KEY_W'(row);
    probeCol   = KEY_W'(col);
    probeData  = DATA_W'(data);
    @(negedge clk);
    probeValid = 1'b0;
  endtask

  task automatic checkItem(input string req, input int left, input int right, input int col);
    chk({req, " outValid"}, int'(outValid), 1);
    chk({req, " outLeft"},  int'(outLeft),  left);
    chk({req, " outRight"}, int'(outRight), right);
    chk({req, " outCol"},   int'(outCol),   col);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 loadReady", int'(loadReady), 1);
    chk("R1 probeReady", int'(probeReady), 1);
    chk("R1 rowEnd", int'(rowEnd), 0);
    probe(0, 0, 16'h1234);
    chk("R1 empty store misses", int'(outValid), 0);

    // Bundle A: keys 3,7,9,7,12 ; values 0x100..0x104
    startBundle(5, 1'b0);
    chk("R3 loadReady low while loading", int'(loadReady), 0);
    chk("R3 probeReady low while loading", int'(probeReady), 0);
    loadElem(3, 16'h0100);
    loadElem(7, 16'h0101);
    loadElem(9, 16'h0102);
    loadElem(7, 16'h0103);
    chk("R3 probeReady low before last element", int'(probeReady), 0);
    loadElem(12, 16'h0104);
    chk("R3 probeReady back after last element", int'(probeReady), 1);
    chk("R3 loadReady back after last element", int'(loadReady), 1);
    chk("R8 rowEnd follows bundle flag", int'(rowEnd), 0);

    // Table walk: R4 hits, R5 misses, R6 duplicate key 7
    for (int v = 0; v < 7; v++) begin
      logic [VW-1:0] e;
      int row, col, data, expHit, expLeft;
      e       = VEC[v];
      row     = int'(e[VW-1 -: KEY_W]);
      col     = int'(e[VW-KEY_W-1 -: KEY_W]);
      data    = int'(e[2*DATA_W -: DATA_W]);
      expHit  = int'(e[DATA_W]);
      expLeft = int'(e[DATA_W-1:0]);
      probe(row, col, data);
      if (expHit != 0) begin
        checkItem((row == 7) ? "R6 lowest duplicate" : "R4 hit item", expLeft, data, col);
      end else begin
        chk("R5 miss queues nothing", int'(outValid), 0);
      end
    end
    @(negedge clk);
    chk("R4 queue drained", int'(outValid), 0);

    // Bundle B closes the row; surplus beat must be ignored
    startBundle(3, 1'b1);
    chk("R8 rowEnd set by new bundle", int'(rowEnd), 1);
    loadElem(20, 16'h0200);
    loadElem(21, 16'h0201);
    loadElem(22, 16'h0202);
    loadElem(23, 16'h0203);
    probe(3, 9, 16'hB000);
    chk("R2 old key cleared", int'(outValid), 0);
    probe(23, 9, 16'hB001);
    chk("R8 surplus beat not stored", int'(outValid), 0);
    probe(22, 9, 16'hB002);
    checkItem("R4 hit second bundle", 16'h0202, 16'hB002, 9);
    @(negedge clk);

    // Zero-length bundle
    startBundle(0, 1'b0);
    chk("R8 zero count ready at once", int'(loadReady), 1);
    chk("R8 zero count probe ready", int'(probeReady), 1);
    chk("R8 zero count rowEnd", int'(rowEnd), 0);
    probe(20, 1, 16'hC000);
    chk("R8 zero count store empty", int'(outValid), 0);

    // Full capacity bundle
    startBundle(CAM_DEPTH, 1'b0);
    for (int i = 0; i < CAM_DEPTH; i++) loadElem(40 + i, 16'h0400 + i);
    probe(40 + CAM_DEPTH - 1, 3, 16'hD000);
    checkItem("R9 last entry hits", 16'h0400 + CAM_DEPTH - 1, 16'hD000, 3);
    probe(40, 4, 16'hD001);
    checkItem("R9 first entry hits", 16'h0400, 16'hD001, 4);
    @(negedge clk);

    // Queue full: stall the consumer
    outReady = 1'b0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      chk("R7 ready before full", int'(probeReady), 1);
      probe(41 + i, 10 + i, 16'hE000 + i);
    end
    chk("R7 probeReady low when full", int'(probeReady), 0);
    probeValid = 1'b1;
    probeRow   = KEY_W'(45);
    probeCol   = KEY_W'(30);
    probeData  = DATA_W'(16'hEEEE);
    repeat (2) begin
      @(negedge clk);
      chk("R7 still blocked", int'(probeReady), 0);
      checkItem("R10 head held", 16'h0401, 16'hE000, 10);
    end
    probeValid = 1'b0;
    outReady   = 1'b1;
    for (int i = 0; i < Q_DEPTH; i++) begin
      checkItem("R7 drain order", 16'h0401 + i, 16'hE000 + i, 10 + i);
      @(negedge clk);
    end
    chk("R7 no extra item", int'(outValid), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule